// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This peripheral keeps time as a 47-bit tick count advanced by a slow 32.768 kHz tick. The tick arrives as a one-cycle enable in the bus clock domain. The low 15 bits of the count are sub-second ticks, so software reads whole seconds as the count shifted right by 15. Software sees the count as two 32-bit words. The two words can change between reads, so software reads them again until two reads agree. Software loads a new time only while the counter is stopped.

A 32-bit alarm register is compared with the seconds value. On a match, while the alarm is in effect, a sticky flag is raised. Software clears the flag by writing one to it. The flag drives an interrupt, and also a wakeup line when wakeup is enabled. The counter-enable and alarm-enable control bits pass through a three-tick delay line before they take effect, which models the lag of the slow domain. A control read returns the value that is in effect, so software polls until the bit matches what it wrote. A 32-bit scratch register is plain read/write storage.

Top module: `lp_secs_rtc`

## Requirements
- R1: After reset every register reads zero, and both interrupt outputs are low.
- R2: Word offsets are: control 0x04, status 0x18, count high 0x1C, count low 0x20, alarm 0x24, scratch 0x30. The scratch register keeps any 32-bit value written to it. Reads of any other offset return zero. Read data appears in the cycle after the read strobe.
- R3: Control bit 0 (counter run) and bit 1 (alarm on) take effect, and read back with their new value, only on the third slow tick after the write. Control bit 3 (wakeup on) takes effect and reads back at once.
- R4: While the counter is stopped, a write to the count low word loads count bits [31:0]. A write to the count high word loads bits [46:32] from write-data bits [14:0]. The high word reads back bits [46:32], zero-extended.
- R5: The count rises by exactly one on each slow tick while the run bit is in effect, and holds otherwise.
- R6: Writes to either count word are ignored while the run bit is in effect.
- R7: A carry out of bit 31 enters the high word. The count wraps from all ones in 47 bits to zero.
- R8: Status bit 0 is set when the alarm bit is in effect and count bits [46:15] equal the alarm register. It is never set while the alarm bit is not in effect.
- R9: Writing a one to status bit 0 clears it. Writing a zero has no effect. When a set and a clear occur in the same cycle, the set wins.
- R10: The interrupt output is status bit 0 AND the alarm bit in effect. The wakeup output additionally requires the wakeup bit. Both outputs are registered, one cycle behind their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| alarm_irq | output | 1 | Alarm interrupt |
| wake_irq | output | 1 | Wakeup request |

## Verification
The bench counts ticks around each control write and checks that the enable bits stay at their old value through the second tick and change on the third. A delay line that is one stage short or one stage long therefore reads back the new value too early or too late. It loads counts just below the carry from the low word and just below the 47-bit wrap. A counter that drops the carry shows a stale high word, and one that is wider than 47 bits shows a non-zero high word after the wrap. It raises the alarm flag and then tries to clear it with a zero write, with a one written while the seconds value still matches, and with the alarm bit disabled. A flag that clears on any write, or that gives the clear priority over a match, is reported. Lastly it checks that wakeup stays low when the wakeup bit is clear but the alarm interrupt is high.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int OFF_CTRL   = 'h04;
  localparam int OFF_STAT   = 'h18;
  localparam int OFF_CNT_HI = 'h1C;
  localparam int OFF_CNT_LO = 'h20;
  localparam int OFF_ALARM  = 'h24;
  localparam int OFF_SCRATCH= 'h30;
  localparam int CB_RUN     = 0;
  localparam int CB_ALARM   = 1;
  localparam int CB_WAKE    = 3;
  localparam int DATA_W     = 32;
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else if (tick) begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

  // R3: the delayed value only moves on a slow tick
  a_r3_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dout));
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter #(
  parameter int CNT_W = 47
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [31:0]      lo_data,
  input  logic [CNT_W-33:0] hi_data,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (!run) begin
      if (ld_lo) count[31:0]       <= lo_data;
      if (ld_hi) count[CNT_W-1:32] <= hi_data;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  // R5: one step per tick while running
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> count == $past(count) + 1'b1);
  // R5: stopped and not loaded means the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_lo && !ld_hi) |=> $stable(count));
  // R6: loads are ignored while running
  a_r6_locked: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && (ld_lo || ld_hi)) |=> $stable(count));
endmodule

// File: rtl/lp_rtc_alarm.sv
module lp_rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] secs,
  input  logic [SEC_W-1:0] alarm_at,
  input  logic             alarm_on,
  input  logic             wake_on,
  input  logic             clr,
  output logic             flag,
  output logic             irq,
  output logic             wake
);
  logic hit;
  assign hit = alarm_on && (secs == alarm_at);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      irq  <= flag && alarm_on;
      wake <= flag && alarm_on && wake_on;
    end
  end

  // R8: a match with the alarm in effect raises the flag
  a_r8_set: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R9: a clear with no match drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
  // R10: wakeup never without the interrupt
  a_r10_wake_needs_irq: assert property (@(posedge clk) disable iff (rst)
    wake |-> irq);
endmodule

// File: rtl/lp_secs_rtc.sv
module lp_secs_rtc
  import lp_rtc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 47,
  parameter int SUB_W      = 15,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              alarm_irq,
  output logic              wake_irq
);
  localparam int HI_W  = CNT_W - 32;
  localparam int SEC_W = CNT_W - SUB_W;

  logic wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alarm, wr_scr;
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_hi    = bus_wr && (bus_addr == ADDR_W'(OFF_CNT_HI));
  assign wr_lo    = bus_wr && (bus_addr == ADDR_W'(OFF_CNT_LO));
  assign wr_alarm = bus_wr && (bus_addr == ADDR_W'(OFF_ALARM));
  assign wr_scr   = bus_wr && (bus_addr == ADDR_W'(OFF_SCRATCH));

  logic [1:0]       en_req, en_eff;
  logic             wake_en;
  logic [SEC_W-1:0] alarm_q;
  logic [31:0]      scratch_q;
  logic [CNT_W-1:0] count;
  logic             flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_req    <= '0;
      wake_en   <= 1'b0;
      alarm_q   <= '0;
      scratch_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_req  <= {bus_wdata[CB_ALARM], bus_wdata[CB_RUN]};
        wake_en <= bus_wdata[CB_WAKE];
      end
      if (wr_alarm) alarm_q   <= bus_wdata[SEC_W-1:0];
      if (wr_scr)   scratch_q <= bus_wdata;
    end
  end

  lp_rtc_sync #(.W(2), .STAGES(SYNC_TICKS)) u_sync (
    .clk(clk), .rst(rst), .tick(slow_tick), .din(en_req), .dout(en_eff)
  );

  lp_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(slow_tick), .run(en_eff[0]),
    .ld_lo(wr_lo), .ld_hi(wr_hi),
    .lo_data(bus_wdata), .hi_data(bus_wdata[HI_W-1:0]),
    .count(count)
  );

  lp_rtc_alarm #(.SEC_W(SEC_W)) u_alm (
    .clk(clk), .rst(rst), .secs(count[CNT_W-1:SUB_W]), .alarm_at(alarm_q),
    .alarm_on(en_eff[1]), .wake_on(wake_en), .clr(wr_stat && bus_wdata[0]),
    .flag(flag), .irq(alarm_irq), .wake(wake_irq)
  );

  logic [31:0] ctrl_view;
  always_comb begin
    ctrl_view           = '0;
    ctrl_view[CB_RUN]   = en_eff[0];
    ctrl_view[CB_ALARM] = en_eff[1];
    ctrl_view[CB_WAKE]  = wake_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFF_CTRL))          bus_rdata <= ctrl_view;
      else if (bus_addr == ADDR_W'(OFF_STAT))     bus_rdata <= {31'b0, flag};
      else if (bus_addr == ADDR_W'(OFF_CNT_HI))   bus_rdata <= {{(32-HI_W){1'b0}}, count[CNT_W-1:32]};
      else if (bus_addr == ADDR_W'(OFF_CNT_LO))   bus_rdata <= count[31:0];
      else if (bus_addr == ADDR_W'(OFF_ALARM))    bus_rdata <= 32'(alarm_q);
      else if (bus_addr == ADDR_W'(OFF_SCRATCH))  bus_rdata <= scratch_q;
      else                                        bus_rdata <= '0;
    end
  end

  // R10: the interrupt follows flag and effective alarm bit by one cycle
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> $past(flag && en_eff[1]));
  // R2: scratch write is visible on a following read
  a_r2_scratch: assert property (@(posedge clk) disable iff (rst)
    (wr_scr && !bus_rd) |=> scratch_q == $past(bus_wdata));
endmodule

// File: tb/lp_secs_rtc_tb_top.sv
module lp_secs_rtc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic alarm_irq, wake_irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  lp_secs_rtc dut_i (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq), .wake_irq(wake_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(8'h04, 32'h0, "R1 ctrl");
    rd(8'h18, 32'h0, "R1 status");
    rd(8'h1C, 32'h0, "R1 count hi");
    rd(8'h20, 32'h0, "R1 count lo");
    rd(8'h24, 32'h0, "R1 alarm");
    rd(8'h30, 32'h0, "R1 scratch");
    chk("R1 irq", {31'b0, alarm_irq}, 32'h0);
    chk("R1 wake", {31'b0, wake_irq}, 32'h0);
    // R2 scratch and unmapped
    wr(8'h30, 32'hA5C3_1E77);
    rd(8'h30, 32'hA5C3_1E77, "R2 scratch");
    rd(8'h08, 32'h0, "R2 unmapped");
    // R4 loads while stopped
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0000_7FFF, "R4 hi width");
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h0002_8000);
    rd(8'h20, 32'h0002_8000, "R4 lo load");
    // R3 run bit delay
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R3 no effect yet");
    tick(2);
    rd(8'h04, 32'h0, "R3 after two ticks");
    rd(8'h20, 32'h0002_8000, "R5 held while stopped");
    tick(1);
    rd(8'h04, 32'h1, "R3 after third tick");
    tick(1);
    rd(8'h20, 32'h0002_8001, "R5 one step");
    // R6 load ignored while running
    wr(8'h20, 32'h0);
    wr(8'h1C, 32'h5);
    rd(8'h20, 32'h0002_8001, "R6 lo ignored");
    rd(8'h1C, 32'h0, "R6 hi ignored");
    // R7 carry into high word
    wr(8'h04, 32'h0); tick(3);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h1C, 32'h12);
    wr(8'h04, 32'h1); tick(3); tick(1);
    rd(8'h20, 32'h0, "R7 carry lo");
    rd(8'h1C, 32'h13, "R7 carry hi");
    // R7 wrap at 47 bits
    wr(8'h04, 32'h0); tick(3);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h1C, 32'h7FFF);
    wr(8'h04, 32'h1); tick(3); tick(1);
    rd(8'h1C, 32'h0, "R7 wrap hi");
    rd(8'h20, 32'h0, "R7 wrap lo");
    // R8 alarm match
    wr(8'h04, 32'h0); tick(3);
    wr(8'h20, 32'h0003_FFFE); wr(8'h1C, 32'h0);
    wr(8'h24, 32'h8);
    wr(8'h04, 32'h0B);
    rd(8'h04, 32'h08, "R3 wake bit immediate");
    tick(3);
    rd(8'h18, 32'h0, "R8 no match yet");
    tick(1);
    rd(8'h18, 32'h0, "R8 one tick short");
    chk("R10 irq low before match", {31'b0, alarm_irq}, 32'h0);
    tick(1);
    rd(8'h18, 32'h1, "R8 flag set on match");
    rd(8'h20, 32'h0004_0000, "R5 seconds boundary");
    chk("R10 irq", {31'b0, alarm_irq}, 32'h1);
    chk("R10 wake", {31'b0, wake_irq}, 32'h1);
    // R9 clearing rules
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h1, "R9 zero write no effect");
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h1, "R9 set wins over clear");
    wr(8'h04, 32'h09); tick(3);
    repeat (2) @(negedge clk);
    chk("R10 irq off with alarm off", {31'b0, alarm_irq}, 32'h0);
    chk("R10 wake off with alarm off", {31'b0, wake_irq}, 32'h0);
    rd(8'h18, 32'h1, "R9 flag sticky");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R9 cleared");
    tick(1);
    rd(8'h18, 32'h0, "R8 no set with alarm off");
    // R10 wakeup gating
    wr(8'h04, 32'h03); tick(3);
    repeat (2) @(negedge clk);
    rd(8'h18, 32'h1, "R8 reset by match");
    chk("R10 irq again", {31'b0, alarm_irq}, 32'h1);
    chk("R10 wake gated", {31'b0, wake_irq}, 32'h0);
    rd(8'h04, 32'h03, "R3 readback");
    finish_run();
  end
endmodule